// File: doc/BRIEF.md
# Zero-Address Stack Expression Unit

This block evaluates arithmetic written in postfix form on an operand stack. Each instruction it accepts carries a two-bit operation and a data-memory address. Push loads a word from data memory onto the stack. Pop stores the top of stack to data memory. Add and multiply take no address: they consume the two uppermost entries and leave one result in their place. For example, `a*(b+c)` runs as push a, push b, push c, add, mul, pop x.

The stack lives in an internal register file indexed by a stack pointer. The pointer starts at DEPTH when the stack is empty and falls by one for every push, so the stack grows toward lower indices. The topmost value is held in a register, and the entries below it sit in a synchronous RAM.

Data memory is reached through a single synchronous port. It has a read strobe and a write strobe, and read data returns one cycle after the read strobe. A push onto a full stack, and an operation that lacks operands, is refused and reported by a one-cycle flag. Neither changes the stack.

Top module: `stack_expr_unit`

## Requirements
- R1: After synchronous reset the unit shows an empty stack: `stack_ptr` = DEPTH, `tos_data` = 0, both flags low, both memory strobes low and `instr_ready` high.
- R2: Opcode 2'b00 is push. One cycle after acceptance, `dmem_rd` is high for exactly one cycle with `dmem_addr` equal to the instruction address. The word returned on `dmem_rdata` in the following cycle becomes `tos_data`, and `stack_ptr` drops by one. `instr_ready` is low for two cycles after the accepting edge.
- R3: A push while `stack_ptr` = 0 raises `ovf_flag` for one cycle, starts no memory read and leaves `stack_ptr` and `tos_data` unchanged.
- R4: Opcode 2'b01 is pop. One cycle after acceptance, `dmem_wr` is high for one cycle, carrying the instruction address and the old top value, and `stack_ptr` rises by one. The entry below becomes `tos_data` one cycle later, during one cycle of `instr_ready` low. Popping the last entry completes with no busy cycle and leaves `tos_data` = 0.
- R5: Opcode 2'b10 is add. It replaces the two uppermost entries with their sum modulo 2^DATA_W, raises `stack_ptr` by one and holds `instr_ready` low for one cycle.
- R6: Opcode 2'b11 is multiply. It behaves like add but leaves the low DATA_W bits of the product.
- R7: Pop on an empty stack, or add or multiply with fewer than two entries, raises `udf_flag` for one cycle. Such an instruction issues no memory strobe and leaves `stack_ptr` and `tos_data` unchanged.
- R8: While `instr_ready` is low, `instr_valid` is ignored. An instruction offered then changes neither the result nor the stack.
- R9: The stack holds exactly DEPTH entries, and they come back in last-in, first-out order. `stack_ptr` never exceeds DEPTH.
- R10: The sequence push a, push b, push c, add, mul, pop x stores a*(b+c) modulo 2^DATA_W at x and leaves the stack empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction offered |
| instr_ready | output | 1 | Unit idle, instruction taken on this edge if valid |
| instr_op | input | 2 | 00 push, 01 pop, 10 add, 11 multiply |
| instr_addr | input | ADDR_W | Data-memory address for push and pop |
| dmem_rd | output | 1 | Data-memory read strobe |
| dmem_wr | output | 1 | Data-memory write strobe |
| dmem_addr | output | ADDR_W | Data-memory address |
| dmem_wdata | output | DATA_W | Data-memory write data |
| dmem_rdata | input | DATA_W | Data-memory read data, one cycle after `dmem_rd` |
| tos_data | output | DATA_W | Current top of stack |
| stack_ptr | output | $clog2(DEPTH+1) | Index of the top entry, DEPTH when empty |
| ovf_flag | output | 1 | One-cycle overflow report |
| udf_flag | output | 1 | One-cycle underflow report |

## Verification
The bench offers each instruction just after a falling edge, so the instruction is taken at the next rising edge. The bench reads the flags and strobes at the falling edge that follows; every refused instruction and every memory strobe is due there.

The bench then counts falling edges with `instr_ready` low: two for a push, one for a refilling pop or an arithmetic operation, and none otherwise. It compares `tos_data` and `stack_ptr` only after ready returns. Memory writes land at the edge after the strobe, so the bench waits one more falling edge before it reads back its own model memory.

// File: rtl/stack_expr_pkg.sv
package stack_expr_pkg;

  typedef enum logic [1:0] {
    OP_PUSH = 2'b00,
    OP_POP  = 2'b01,
    OP_ADD  = 2'b10,
    OP_MUL  = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LOAD,
    ST_REFILL,
    ST_ARITH
  } state_e;

endpackage

// File: rtl/stack_expr_ram.sv
module stack_expr_ram #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] cells_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      cells_q[wr_idx] <= wr_data;
    end
    rd_data <= cells_q[rd_idx];
  end

endmodule

// File: rtl/stack_expr_alu.sv
module stack_expr_alu #(
  parameter int DATA_W = 16
) (
  input  logic              mul_sel,
  input  logic [DATA_W-1:0] lower,
  input  logic [DATA_W-1:0] upper,
  output logic [DATA_W-1:0] result
);

  logic [DATA_W-1:0] sum_lo;
  logic [DATA_W-1:0] prod_lo;

  assign sum_lo  = lower + upper;
  assign prod_lo = lower * upper;
  assign result  = mul_sel ? prod_lo : sum_lo;

endmodule

// File: rtl/stack_expr_guard.sv
module stack_expr_guard #(
  parameter int DEPTH = 16,
  parameter int SP_W  = 5
) (
  input  logic [SP_W-1:0] sp,
  output logic            is_full,
  output logic            is_empty,
  output logic            is_single,
  output logic            below_two,
  output logic [SP_W-1:0] next_idx
);

  localparam logic [SP_W-1:0] EMPTY_SP  = SP_W'(DEPTH);
  localparam logic [SP_W-1:0] SINGLE_SP = SP_W'(DEPTH - 1);

  assign is_full   = (sp == '0);
  assign is_empty  = (sp == EMPTY_SP);
  assign is_single = (sp == SINGLE_SP);
  assign below_two = is_empty | is_single;
  assign next_idx  = sp + SP_W'(1);

endmodule

// File: rtl/stack_expr_unit.sv
module stack_expr_unit
  import stack_expr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 8,
  localparam int SP_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  output logic              instr_ready,
  input  logic [1:0]        instr_op,
  input  logic [ADDR_W-1:0] instr_addr,
  output logic              dmem_rd,
  output logic              dmem_wr,
  output logic [ADDR_W-1:0] dmem_addr,
  output logic [DATA_W-1:0] dmem_wdata,
  input  logic [DATA_W-1:0] dmem_rdata,
  output logic [DATA_W-1:0] tos_data,
  output logic [SP_W-1:0]   stack_ptr,
  output logic              ovf_flag,
  output logic              udf_flag
);

  state_e            st_q;
  logic [SP_W-1:0]   sp_q;
  logic [DATA_W-1:0] tos_q;
  logic              ovf_q, udf_q, rd_q, wr_q, mul_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  logic              g_full, g_empty, g_single, g_below2;
  logic [SP_W-1:0]   g_next;
  logic [DATA_W-1:0] ram_rdata;
  logic [DATA_W-1:0] alu_y;
  logic              ram_we;
  op_e               op_in;

  assign op_in       = op_e'(instr_op);
  assign instr_ready = (st_q == ST_IDLE);

  stack_expr_guard #(.DEPTH(DEPTH), .SP_W(SP_W)) guard_i (
    .sp        (sp_q),
    .is_full   (g_full),
    .is_empty  (g_empty),
    .is_single (g_single),
    .below_two (g_below2),
    .next_idx  (g_next)
  );

  // The old top is written into the RAM when a pushed word arrives.
  assign ram_we = (st_q == ST_LOAD) && !g_empty;

  stack_expr_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(SP_W)) ram_i (
    .clk     (clk),
    .wr_en   (ram_we),
    .wr_idx  (sp_q),
    .wr_data (tos_q),
    .rd_idx  (g_next),
    .rd_data (ram_rdata)
  );

  stack_expr_alu #(.DATA_W(DATA_W)) alu_i (
    .mul_sel (mul_q),
    .lower   (ram_rdata),
    .upper   (tos_q),
    .result  (alu_y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      sp_q    <= SP_W'(DEPTH);
      tos_q   <= '0;
      ovf_q   <= 1'b0;
      udf_q   <= 1'b0;
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
      mul_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
      rd_q  <= 1'b0;
      wr_q  <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (instr_valid) begin
            unique case (op_in)
              OP_PUSH: begin
                if (g_full) begin
                  ovf_q <= 1'b1;
                end else begin
                  rd_q   <= 1'b1;
                  addr_q <= instr_addr;
                  st_q   <= ST_FETCH;
                end
              end
              OP_POP: begin
                if (g_empty) begin
                  udf_q <= 1'b1;
                end else begin
                  wr_q    <= 1'b1;
                  addr_q  <= instr_addr;
                  wdata_q <= tos_q;
                  sp_q    <= g_next;
                  if (g_single) begin
                    tos_q <= '0;
                  end else begin
                    st_q <= ST_REFILL;
                  end
                end
              end
              default: begin
                if (g_below2) begin
                  udf_q <= 1'b1;
                end else begin
                  mul_q <= (op_in == OP_MUL);
                  st_q  <= ST_ARITH;
                end
              end
            endcase
          end
        end
        ST_FETCH: st_q <= ST_LOAD;
        ST_LOAD: begin
          tos_q <= dmem_rdata;
          sp_q  <= sp_q - SP_W'(1);
          st_q  <= ST_IDLE;
        end
        ST_REFILL: begin
          tos_q <= ram_rdata;
          st_q  <= ST_IDLE;
        end
        ST_ARITH: begin
          tos_q <= alu_y;
          sp_q  <= g_next;
          st_q  <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign dmem_rd    = rd_q;
  assign dmem_wr    = wr_q;
  assign dmem_addr  = addr_q;
  assign dmem_wdata = wdata_q;
  assign tos_data   = tos_q;
  assign stack_ptr  = sp_q;
  assign ovf_flag   = ovf_q;
  assign udf_flag   = udf_q;

endmodule

// File: rtl/stack_expr_checker.sv
module stack_expr_checker #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 8,
  localparam int SP_W  = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              instr_ready,
  input logic              dmem_rd,
  input logic              dmem_wr,
  input logic [ADDR_W-1:0] dmem_addr,
  input logic [DATA_W-1:0] tos_data,
  input logic [SP_W-1:0]   stack_ptr,
  input logic              ovf_flag,
  input logic              udf_flag
);

  p_reset_empty_r1: assert property (@(posedge clk)
    rst |=> (int'(stack_ptr) == DEPTH && instr_ready && !dmem_rd && !dmem_wr && !ovf_flag && !udf_flag));

  p_single_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    !(dmem_rd && dmem_wr));

  p_push_lowers_sp_r2: assert property (@(posedge clk) disable iff (rst)
    dmem_rd |-> ##2 (int'(stack_ptr) + 1 == int'($past(stack_ptr, 2))));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    ovf_flag |-> (stack_ptr == '0 && $stable(stack_ptr) && $stable(tos_data) && !dmem_rd));

  p_pop_raises_sp_r4: assert property (@(posedge clk) disable iff (rst)
    dmem_wr |-> (int'(stack_ptr) == int'($past(stack_ptr)) + 1));

  p_no_underflow_r7: assert property (@(posedge clk) disable iff (rst)
    udf_flag |-> ($stable(stack_ptr) && $stable(tos_data) && !dmem_wr && !dmem_rd
                  && int'(stack_ptr) >= DEPTH - 1));

  p_sp_bounded_r9: assert property (@(posedge clk) disable iff (rst)
    int'(stack_ptr) <= DEPTH);

endmodule

bind stack_expr_unit stack_expr_checker #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .instr_ready (instr_ready),
  .dmem_rd     (dmem_rd),
  .dmem_wr     (dmem_wr),
  .dmem_addr   (dmem_addr),
  .tos_data    (tos_data),
  .stack_ptr   (stack_ptr),
  .ovf_flag    (ovf_flag),
  .udf_flag    (udf_flag)
);

// File: tb/stack_expr_unit_tb.sv
module stack_expr_unit_tb_top;

  localparam int CLK_P = 10;
  localparam int DW    = 8;
  localparam int DP    = 4;
  localparam int AW    = 4;
  localparam int SPW   = $clog2(DP + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          instr_valid = 1'b0;
  logic          instr_ready;
  logic [1:0]    instr_op = 2'b00;
  logic [AW-1:0] instr_addr = '0;
  logic          dmem_rd, dmem_wr;
  logic [AW-1:0] dmem_addr;
  logic [DW-1:0] dmem_wdata;
  logic [DW-1:0] dmem_rdata = '0;
  logic [DW-1:0] tos_data;
  logic [SPW-1:0] stack_ptr;
  logic          ovf_flag, udf_flag;

  logic [DW-1:0] src  [16];
  logic [DW-1:0] sink [16];

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  bit r_ov, r_ud, r_rd, r_wr;
  int r_busy;
  int r_addr, r_wdata;

  always #(CLK_P / 2) clk = ~clk;

  stack_expr_unit #(.DATA_W(DW), .DEPTH(DP), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst),
    .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr_op(instr_op), .instr_addr(instr_addr),
    .dmem_rd(dmem_rd), .dmem_wr(dmem_wr), .dmem_addr(dmem_addr),
    .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
    .tos_data(tos_data), .stack_ptr(stack_ptr),
    .ovf_flag(ovf_flag), .udf_flag(udf_flag)
  );

  always @(posedge clk) begin
    if (dmem_rd) dmem_rdata <= src[dmem_addr];
    if (dmem_wr) sink[dmem_addr] <= dmem_wdata;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // Offer one instruction; record flags and strobes one cycle after acceptance
  // and the number of busy cycles. With junk set, a multiply is offered
  // throughout the busy window.
  task automatic do_op(input logic [1:0] op, input int addr, input bit junk);
    int guard;
    @(negedge clk);
    guard = 0;
    while (!instr_ready && guard < 50) begin
      @(negedge clk);
      guard++;
    end
    instr_valid = 1'b1;
    instr_op    = op;
    instr_addr  = AW'(addr);
    @(negedge clk);
    r_ov = ovf_flag; r_ud = udf_flag; r_rd = dmem_rd; r_wr = dmem_wr;
    r_addr = int'(dmem_addr); r_wdata = int'(dmem_wdata);
    instr_op    = 2'b11;
    instr_addr  = '0;
    instr_valid = junk && !instr_ready;
    r_busy = 0;
    while (!instr_ready && r_busy < 50) begin
      @(negedge clk);
      r_busy++;
      instr_valid = junk && !instr_ready;
    end
    instr_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      src[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 sp", int'(stack_ptr), DP);
    chk("R1 top", int'(tos_data), 0);
    chk("R1 ready", int'(instr_ready), 1);
    chk("R1 flags", int'({ovf_flag, udf_flag}), 0);
    chk("R1 strobes", int'({dmem_rd, dmem_wr}), 0);

    // R7 underflow on empty and single-entry stacks
    do_op(2'b01, 2, 0);
    chk("R7 pop empty udf", int'(r_ud), 1);
    chk("R7 pop empty no write", int'(r_wr), 0);
    chk("R7 pop empty sp", int'(stack_ptr), DP);
    do_op(2'b10, 0, 0);
    chk("R7 add empty udf", int'(r_ud), 1);
    chk("R7 add empty sp", int'(stack_ptr), DP);
    src[0] = 8'd77;
    do_op(2'b00, 0, 0);
    do_op(2'b11, 0, 0);
    chk("R7 mul single udf", int'(r_ud), 1);
    chk("R7 mul single sp", int'(stack_ptr), DP - 1);
    chk("R7 mul single top", int'(tos_data), 77);
    // R4 popping the last entry
    do_op(2'b01, 3, 0);
    chk("R4 last pop busy", r_busy, 0);
    chk("R4 last pop write", int'(r_wr), 1);
    chk("R4 last pop data", int'(sink[3]), 77);
    chk("R4 last pop top", int'(tos_data), 0);
    chk("R4 last pop sp", int'(stack_ptr), DP);

    // R2 R8 R9 fill the stack, with junk offered while busy
    for (int i = 0; i < DP; i++) begin
      src[i] = DW'(11 * (i + 1));
    end
    for (int i = 0; i < DP; i++) begin
      do_op(2'b00, i, 1);
      chk("R2 push read strobe", int'(r_rd), 1);
      chk("R2 push read addr", r_addr, i);
      chk("R2 push busy", r_busy, 2);
      chk("R8 push top", int'(tos_data), 11 * (i + 1));
      chk("R9 push sp", int'(stack_ptr), DP - 1 - i);
    end
    // R3 overflow on full stack
    do_op(2'b00, 5, 0);
    chk("R3 ovf", int'(r_ov), 1);
    chk("R3 no read", int'(r_rd), 0);
    chk("R3 sp", int'(stack_ptr), 0);
    chk("R3 top", int'(tos_data), 11 * DP);
    // R4 R9 drain in reverse order
    for (int i = DP - 1; i >= 0; i--) begin
      do_op(2'b01, 8 + i, 0);
      chk("R4 pop write addr", r_addr, 8 + i);
      chk("R9 pop data", int'(sink[8 + i]), 11 * (i + 1));
      chk("R4 pop busy", r_busy, (i == 0) ? 0 : 1);
      chk("R4 pop top", int'(tos_data), (i == 0) ? 0 : 11 * i);
      chk("R4 pop sp", int'(stack_ptr), DP - i);
    end

    // R5 R6 sweep of operand pairs
    for (int ai = 0; ai < 16; ai++) begin
      for (int bi = 0; bi < 16; bi++) begin
        for (int m = 0; m < 2; m++) begin
          int a, b, expv;
          a = (ai == 15) ? 255 : ai * 17;
          b = (bi == 15) ? 255 : (bi * 29 + 7) % 256;
          expv = (m == 1) ? (a * b) % 256 : (a + b) % 256;
          src[0] = DW'(a);
          src[1] = DW'(b);
          do_op(2'b00, 0, 0);
          do_op(2'b00, 1, 0);
          do_op((m == 1) ? 2'b11 : 2'b10, 0, 0);
          chk((m == 1) ? "R6 mul busy" : "R5 add busy", r_busy, 1);
          chk((m == 1) ? "R6 mul result" : "R5 add result", int'(tos_data), expv);
          chk((m == 1) ? "R6 mul sp" : "R5 add sp", int'(stack_ptr), DP - 1);
          do_op(2'b01, 6, 0);
          chk("R4 sweep pop data", int'(sink[6]), expv);
        end
      end
    end

    // R10 postfix expression a*(b+c), one plain and one wrapping case
    for (int k = 0; k < 2; k++) begin
      int a, b, c;
      a = (k == 0) ? 9 : 200;
      b = (k == 0) ? 20 : 100;
      c = (k == 0) ? 7 : 60;
      src[2] = DW'(a); src[3] = DW'(b); src[4] = DW'(c);
      do_op(2'b00, 2, 0);
      do_op(2'b00, 3, 0);
      do_op(2'b00, 4, 0);
      do_op(2'b10, 0, 0);
      do_op(2'b11, 0, 0);
      do_op(2'b01, 12, 0);
      chk("R10 expression", int'(sink[12]), (a * (b + c)) % 256);
      chk("R10 empty after", int'(stack_ptr), DP);
    end

    summary();
  end

endmodule